// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a clocked 3-bit counter. It steps through five fixed codes that do not form a binary count. Each state bit has its own next-state equation, and those equations give every one of the eight possible codes a defined successor. Because of this, the three codes outside the sequence always lead back into it. The counter does not depend on a reset to leave a bad code after power-up.

The state leaves the block on `code_o`, ordered (C,B,A) with C as bit 2. The `valid_o` flag is high while the present code is one of the five sequence codes.

The `INIT_CODE` parameter sets the power-up value of the state register. It models a counter that wakes up in an arbitrary code.

The codes are named as follows:

- The sequence codes are SEQ_P0=000, SEQ_P1=010, SEQ_P2=011, SEQ_P3=101 and SEQ_P4=110.
- The unused codes are ORPH_1=001, ORPH_4=100 and ORPH_7=111.

On each enabled clock the counter takes one of these transitions:

- P0→P1, P1→P2, P2→P3, P3→P4 and P4→P0 along the sequence.
- ORPH_1→P4.
- ORPH_4→P1.
- ORPH_7→ORPH_4.

Top module: `seq5_counter`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the code becomes 000 on that edge, whatever the value of `en_i`.
- R2: With `rst_i` low and `en_i` low, `code_o` keeps its value across the edge.
- R3: With `en_i` high and `rst_i` low, each edge advances `code_o` through 000, 010, 011, 101, 110 and then back to 000, with `code_o` read as {C,B,A}.
- R4: The unused code 001 moves to 110 on one enabled edge.
- R5: The unused code 100 moves to 010 on one enabled edge.
- R6: The unused code 111 moves to 100 on one enabled edge, and then to 010 on the next.
- R7: `valid_o` is 1 for the codes 000, 010, 011, 101 and 110, and 0 for the codes 001, 100 and 111.
- R8: The register starts at `INIT_CODE` with no reset applied. From any start code, at most two enabled edges bring it to a code with `valid_o` equal to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset to 000, which wins over enable |
| en_i | input | 1 | Count enable; when low, the counter holds its code |
| code_o | output | 3 | Present code {C,B,A} |
| valid_o | output | 1 | High when the present code is one of the five sequence codes |

## Verification
The bench powers up separate copies of the counter in 001, 100 and 111 and watches them recover with no reset. A design whose unused codes were left to chance would lock up or wander in this test. The 111 case needs its two-step path: going straight to 010, or stalling in 100, would both be caught. Reset is asserted together with enable to show that reset wins. Enable is dropped partway through the sequence to expose a counter that slips a step while it should hold. The last check is the wrap from 110 to 000, which a design that continued counting in binary would get wrong.

// File: rtl/seq5_pkg.sv
package seq5_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        SEQ_P0 = 3'b000,
        ORPH_1 = 3'b001,
        SEQ_P1 = 3'b010,
        SEQ_P2 = 3'b011,
        ORPH_4 = 3'b100,
        SEQ_P3 = 3'b101,
        SEQ_P4 = 3'b110,
        ORPH_7 = 3'b111
    } code_e;

endpackage

// File: rtl/seq5_next.sv
module seq5_next
    import seq5_pkg::*;
(
    input  code_e cur_i,
    output code_e nxt_o
);
    logic c_bit, b_bit, a_bit;
    logic c_nxt, b_nxt, a_nxt;

    assign {c_bit, b_bit, a_bit} = cur_i;

    always_comb begin
        c_nxt = a_bit;
        b_nxt = ~b_bit | (~a_bit & ~c_bit);
        a_nxt = b_bit & ~c_bit;
    end

    assign nxt_o = code_e'({c_nxt, b_nxt, a_nxt});
endmodule

// File: rtl/seq5_decode.sv
module seq5_decode
    import seq5_pkg::*;
(
    input  code_e cur_i,
    output logic  valid_o
);
    always_comb begin
        unique case (cur_i)
            SEQ_P0, SEQ_P1, SEQ_P2, SEQ_P3, SEQ_P4: valid_o = 1'b1;
            ORPH_1, ORPH_4, ORPH_7:                 valid_o = 1'b0;
            default:                                valid_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/seq5_counter.sv
module seq5_counter
    import seq5_pkg::*;
#(
    parameter logic [2:0] INIT_CODE = 3'b000
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    output logic [2:0] code_o,
    output logic       valid_o
);
    code_e state_q = code_e'(INIT_CODE);
    code_e state_d;

    seq5_next u_next (
        .cur_i (state_q),
        .nxt_o (state_d)
    );

    seq5_decode u_decode (
        .cur_i   (state_q),
        .valid_o (valid_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SEQ_P0;
        end else if (en_i) begin
            state_q <= state_d;
        end
    end

    assign code_o = state_q;

    // Reset drives 000 regardless of enable
    assert_reset_zero_R1: assert property (@(posedge clk_i)
        rst_i |=> (code_o == 3'b000));

    // Hold while not enabled
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(code_o));

    // The sequence never leaves itself
    assert_stay_valid_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && valid_o) |=> valid_o);

    // Unused 001 and 100 recover in one step
    assert_orph_one_step_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && (code_o == 3'b001 || code_o == 3'b100)) |=> valid_o);

    // 111 goes to 100 first
    assert_orph7_path_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && code_o == 3'b111) |=> (code_o == 3'b100));
endmodule

// File: tb/seq5_counter_tb_top.sv
module seq5_counter_tb_top;
    logic clk = 1'b0;
    logic rst, en, en_pu;
    logic [2:0] code, code1, code4, code7;
    logic valid, valid1, valid4, valid7;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seq5_counter #(.INIT_CODE(3'b000)) dut_i (
        .clk_i(clk), .rst_i(rst), .en_i(en), .code_o(code), .valid_o(valid));
    seq5_counter #(.INIT_CODE(3'b001)) pu1_i (
        .clk_i(clk), .rst_i(1'b0), .en_i(en_pu), .code_o(code1), .valid_o(valid1));
    seq5_counter #(.INIT_CODE(3'b100)) pu4_i (
        .clk_i(clk), .rst_i(1'b0), .en_i(en_pu), .code_o(code4), .valid_o(valid4));
    seq5_counter #(.INIT_CODE(3'b111)) pu7_i (
        .clk_i(clk), .rst_i(1'b0), .en_i(en_pu), .code_o(code7), .valid_o(valid7));

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, got, exp);
        end
    endtask

    // One edge with the given inputs, then sample at the falling edge
    task automatic step(input logic r, input logic e);
        rst = r;
        en  = e;
        @(negedge clk);
    endtask

    task automatic t_reset;
        step(1'b1, 1'b0);
        check("R1 reset code", {1'b0, code}, 4'b0000);
        check("R7 valid at 000", {3'b000, valid}, 4'b0001);
    endtask

    task automatic t_sequence;
        logic [2:0] order [5] = '{3'b010, 3'b011, 3'b101, 3'b110, 3'b000};
        for (int i = 0; i < 10; i++) begin
            step(1'b0, 1'b1);
            check("R3 sequence step", {1'b0, code}, {1'b0, order[i % 5]});
            check("R7 valid in sequence", {3'b000, valid}, 4'b0001);
        end
    endtask

    task automatic t_hold;
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        check("R3 reach 011", {1'b0, code}, 4'b0011);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0);
            check("R2 hold", {1'b0, code}, 4'b0011);
        end
        step(1'b0, 1'b1);
        check("R3 resume to 101", {1'b0, code}, 4'b0101);
    endtask

    task automatic t_reset_priority;
        step(1'b1, 1'b1);
        check("R1 reset beats enable", {1'b0, code}, 4'b0000);
    endtask

    task automatic t_powerup;
        check("R8 start 001", {1'b0, code1}, 4'b0001);
        check("R8 start 100", {1'b0, code4}, 4'b0100);
        check("R8 start 111", {1'b0, code7}, 4'b0111);
        check("R7 invalid flags", {1'b0, valid1, valid4, valid7}, 4'b0000);
        en_pu = 1'b1;
        @(negedge clk);
        check("R4 001 to 110", {1'b0, code1}, 4'b0110);
        check("R5 100 to 010", {1'b0, code4}, 4'b0010);
        check("R6 111 to 100", {1'b0, code7}, 4'b0100);
        check("R8 one step flags", {1'b0, valid1, valid4, valid7}, 4'b0110);
        @(negedge clk);
        check("R6 100 to 010", {1'b0, code7}, 4'b0010);
        check("R8 two step flags", {1'b0, valid1, valid4, valid7}, 4'b0111);
        en_pu = 1'b0;
    endtask

    initial begin
        rst = 1'b0;
        en = 1'b0;
        en_pu = 1'b0;
        @(negedge clk);
        t_powerup();
        t_reset();
        t_sequence();
        t_hold();
        t_reset_priority();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule